// File: doc/BRIEF.md
# Read-Add-Write Word Copy Engine

This block is an AXI4-Lite master that needs no software and moves a block of 32-bit words from a source region to a separate destination region. Each word is changed on the way. One rising edge on `start` launches a run of `COUNT` iterations. In every iteration the engine reads one word, adds the constant `ADDEND` to it, and writes the sum to the matching destination word. Only after that write has been acknowledged does the engine read the next word.

The source base, the destination offset, the iteration count and the addend are all parameters. The read data is captured into a hold register only on an accepted read beat, and the write is built from that register. Because of this, a value that appears on the read data bus outside a beat can never reach memory. An error response on either channel ends the run at once. In that case `error` and `done` are raised and no further transaction is issued.

Top module: `rmw_copy_engine`

## Requirements
- R1: Each iteration moves exactly one 32-bit word in one read and one write. The write data equals the data of the accepted read beat plus `ADDEND` modulo 2^32 (default 0xABC00000). For example, 0xFFFFFFFF becomes 0xABBFFFFF.
- R2: One start issues exactly `COUNT` iterations (default 10) for i = 0 to COUNT-1 in ascending order. Iteration i reads from `SRC_BASE + 4*i` and writes to `SRC_BASE + DST_OFFSET + 4*i` (defaults 0x40000000 and offset 0x7CC).
- R3: At most one transaction is outstanding at a time. While a write (AW, W or B phase) is open, ARVALID and RREADY stay low. While a read is open, AWVALID, WVALID and BREADY stay low. ARVALID and ARADDR are held until ARREADY.
- R4: AWVALID and WVALID rise in the same cycle. Each one stays high, with stable address or data, until its own READY is seen, whatever the other channel does.
- R5: BREADY is raised only after both AW and W have completed, and it is held until BVALID. The next ARVALID is low in the cycle after the B handshake.
- R6: The value written is the value held by RDATA at its accepted beat. Whatever RDATA shows outside a beat has no effect on any written word.
- R7: A run begins only on a rising edge of `start`. `busy` is high from the cycle after that edge until the run ends. Keeping `start` high, or pulsing it while `busy` is high, starts no extra run.
- R8: `done` rises with the final B handshake and stays high until the next start edge, which clears it. A run that ends without error leaves `error` at 0. `done` is never high together with `busy`.
- R9: A nonzero RRESP ends the run. The engine raises `error` and `done`, skips the write for that word, and issues no later transaction.
- R10: A nonzero BRESP ends the run. The engine raises `error` and `done` and issues no further read.
- R11: During and directly after synchronous active-low reset, every VALID and READY output is low and `busy`, `done` and `error` are 0. ARPROT and AWPROT are always 0 and WSTRB is always 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Rising edge begins a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished (sticky until next start) |
| error | output | 1 | Last run ended on an error response |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Write protection, always 0 |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes, all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection, always 0 |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The slave model drives junk on RDATA whenever RVALID is low. It also stalls AW and W by different amounts, in both orders. A design that sampled the bus outside the beat, or cleared its capture register between iterations, would write junk or zero over some destination words. A design that waited for both channels before dropping either VALID would show up in the same runs. Every destination word starts out holding a sentinel, so a skipped iteration, an extra write or a write issued after an error response leaves a word that visibly does not match. A second start edge, sent while a run is in progress or held high after it ends, must not add to the read count.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ISSUE,
      ST_RD_WAIT,
      ST_WR_ISSUE,
      ST_WR_WAIT
   } rmw_state_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/rmw_rd_port.sv
module rmw_rd_port #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] m_araddr,
   output logic              m_arvalid,
   input  logic              m_arready,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic [1:0]        m_rresp,
   input  logic              m_rvalid,
   output logic              m_rready,
   output logic              beat,
   output logic              beat_err,
   output logic [DATA_W-1:0] hold_data
);
   import rmw_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_arvalid <= 1'b0;
         m_araddr  <= '0;
         m_rready  <= 1'b0;
         hold_data <= '0;
      end else begin
         if (launch) begin
            m_arvalid <= 1'b1;
            m_araddr  <= addr;
         end else if (m_arvalid && m_arready) begin
            m_arvalid <= 1'b0;
            m_rready  <= 1'b1;
         end
         if (m_rready && m_rvalid) begin
            m_rready  <= 1'b0;
            hold_data <= m_rdata;
         end
      end
   end

   assign beat     = m_rready && m_rvalid;
   assign beat_err = beat && (m_rresp != RESP_OKAY);

endmodule

// File: rtl/rmw_wr_port.sv
module rmw_wr_port #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [ADDR_W-1:0] m_awaddr,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [DATA_W-1:0] m_wdata,
   output logic              m_wvalid,
   input  logic              m_wready,
   input  logic [1:0]        m_bresp,
   input  logic              m_bvalid,
   output logic              m_bready,
   output logic              complete,
   output logic              complete_err
);
   import rmw_pkg::*;

   logic aw_left;
   logic w_left;
   logic any_open;

   assign aw_left  = m_awvalid && !m_awready;
   assign w_left   = m_wvalid && !m_wready;
   assign any_open = m_awvalid || m_wvalid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_awvalid <= 1'b0;
         m_wvalid  <= 1'b0;
         m_bready  <= 1'b0;
         m_awaddr  <= '0;
         m_wdata   <= '0;
      end else begin
         if (launch) begin
            m_awvalid <= 1'b1;
            m_wvalid  <= 1'b1;
            m_awaddr  <= addr;
            m_wdata   <= data;
         end else begin
            if (m_awvalid && m_awready) m_awvalid <= 1'b0;
            if (m_wvalid && m_wready)   m_wvalid  <= 1'b0;
            if (any_open && !aw_left && !w_left) m_bready <= 1'b1;
            else if (m_bready && m_bvalid)       m_bready <= 1'b0;
         end
      end
   end

   assign complete     = m_bready && m_bvalid;
   assign complete_err = complete && (m_bresp != RESP_OKAY);

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq #(
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter int                COUNT    = 10,
   parameter logic [ADDR_W-1:0] SRC_BASE = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] DST_BASE = 32'h4000_07CC,
   parameter logic [DATA_W-1:0] ADDEND   = 32'hABC0_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_beat,
   input  logic              rd_err,
   input  logic [DATA_W-1:0] rd_hold,
   input  logic              wr_done,
   input  logic              wr_err,
   output logic              rd_launch,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_launch,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic              error
);
   import rmw_pkg::*;

   localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COUNT - 1);

   rmw_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             start_q;
   logic [ADDR_W-1:0] byte_off;

   assign byte_off = ADDR_W'({idx, 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx     <= '0;
         start_q <= 1'b0;
         done    <= 1'b0;
         error   <= 1'b0;
      end else begin
         start_q <= start;
         case (state)
            ST_IDLE: begin
               if (start && !start_q) begin
                  state <= ST_RD_ISSUE;
                  idx   <= '0;
                  done  <= 1'b0;
                  error <= 1'b0;
               end
            end
            ST_RD_ISSUE: state <= ST_RD_WAIT;
            ST_RD_WAIT: begin
               if (rd_beat) begin
                  if (rd_err) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                     error <= 1'b1;
                  end else begin
                     state <= ST_WR_ISSUE;
                  end
               end
            end
            ST_WR_ISSUE: state <= ST_WR_WAIT;
            ST_WR_WAIT: begin
               if (wr_done) begin
                  if (wr_err) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                     error <= 1'b1;
                  end else if (idx == LAST_IDX) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_RD_ISSUE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign rd_launch = (state == ST_RD_ISSUE);
   assign wr_launch = (state == ST_WR_ISSUE);
   assign rd_addr   = SRC_BASE + byte_off;
   assign wr_addr   = DST_BASE + byte_off;

   generate
      if (ADDEND == '0) begin : g_pass
         assign wr_data = rd_hold;
      end else begin : g_add
         assign wr_data = rd_hold + ADDEND;
      end
   endgenerate

endmodule

// File: rtl/rmw_copy_engine.sv
module rmw_copy_engine #(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 32,
   parameter int                COUNT      = 10,
   parameter logic [ADDR_W-1:0] SRC_BASE   = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] DST_OFFSET = 32'h0000_07CC,
   parameter logic [DATA_W-1:0] ADDEND     = 32'hABC0_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                busy,
   output logic                done,
   output logic                error,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic [2:0]          m_awprot,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wvalid,
   input  logic                m_wready,
   input  logic [1:0]          m_bresp,
   input  logic                m_bvalid,
   output logic                m_bready,
   output logic [ADDR_W-1:0]   m_araddr,
   output logic [2:0]          m_arprot,
   output logic                m_arvalid,
   input  logic                m_arready,
   input  logic [DATA_W-1:0]   m_rdata,
   input  logic [1:0]          m_rresp,
   input  logic                m_rvalid,
   output logic                m_rready
);

   localparam logic [ADDR_W-1:0] DST_BASE  = SRC_BASE + DST_OFFSET;
   localparam logic [ADDR_W-1:0] SPAN_B    = ADDR_W'(4 * COUNT);

   initial begin
      data_w_chk: assert (DATA_W == 32)
         else $error("DATA_W must be 32");
      count_chk: assert (COUNT >= 1)
         else $error("COUNT must be at least 1");
      align_chk: assert (SRC_BASE[1:0] == 2'b00 && DST_OFFSET[1:0] == 2'b00)
         else $error("bases must be word aligned");
      overlap_chk: assert (DST_OFFSET >= SPAN_B)
         else $error("destination region overlaps source region");
   end

   logic              rd_launch;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_beat;
   logic              rd_err;
   logic [DATA_W-1:0] rd_hold;
   logic              wr_launch;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              wr_done;
   logic              wr_err;

   assign m_awprot = 3'b000;
   assign m_arprot = 3'b000;
   assign m_wstrb  = '1;

   rmw_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .COUNT    (COUNT),
      .SRC_BASE (SRC_BASE),
      .DST_BASE (DST_BASE),
      .ADDEND   (ADDEND)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_beat   (rd_beat),
      .rd_err    (rd_err),
      .rd_hold   (rd_hold),
      .wr_done   (wr_done),
      .wr_err    (wr_err),
      .rd_launch (rd_launch),
      .rd_addr   (rd_addr),
      .wr_launch (wr_launch),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .busy      (busy),
      .done      (done),
      .error     (error)
   );

   rmw_rd_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (rd_launch),
      .addr      (rd_addr),
      .m_araddr  (m_araddr),
      .m_arvalid (m_arvalid),
      .m_arready (m_arready),
      .m_rdata   (m_rdata),
      .m_rresp   (m_rresp),
      .m_rvalid  (m_rvalid),
      .m_rready  (m_rready),
      .beat      (rd_beat),
      .beat_err  (rd_err),
      .hold_data (rd_hold)
   );

   rmw_wr_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_wr (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch       (wr_launch),
      .addr         (wr_addr),
      .data         (wr_data),
      .m_awaddr     (m_awaddr),
      .m_awvalid    (m_awvalid),
      .m_awready    (m_awready),
      .m_wdata      (m_wdata),
      .m_wvalid     (m_wvalid),
      .m_wready     (m_wready),
      .m_bresp      (m_bresp),
      .m_bvalid     (m_bvalid),
      .m_bready     (m_bready),
      .complete     (wr_done),
      .complete_err (wr_err)
   );

endmodule

// File: rtl/rmw_copy_engine_chk.sv
module rmw_copy_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                done,
   input logic [ADDR_W-1:0]   m_awaddr,
   input logic [2:0]          m_awprot,
   input logic                m_awvalid,
   input logic                m_awready,
   input logic [DATA_W-1:0]   m_wdata,
   input logic [DATA_W/8-1:0] m_wstrb,
   input logic                m_wvalid,
   input logic                m_wready,
   input logic                m_bvalid,
   input logic                m_bready,
   input logic [ADDR_W-1:0]   m_araddr,
   input logic [2:0]          m_arprot,
   input logic                m_arvalid,
   input logic                m_arready,
   input logic                m_rready
);

   // R4
   aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

   // R4
   w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

   // R4
   aw_w_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_awvalid) |-> $rose(m_wvalid));

   // R3
   ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

   // R3
   rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid || m_rready) |-> !(m_awvalid || m_wvalid || m_bready));

   // R5
   b_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_bready && !m_bvalid) |=> m_bready);

   // R5
   ar_after_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_bready && m_bvalid) |=> !m_arvalid);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11
   fixed_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wstrb == '1) && (m_awprot == 3'b000) && (m_arprot == 3'b000));

endmodule

bind rmw_copy_engine rmw_copy_engine_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .m_awaddr  (m_awaddr),
   .m_awprot  (m_awprot),
   .m_awvalid (m_awvalid),
   .m_awready (m_awready),
   .m_wdata   (m_wdata),
   .m_wstrb   (m_wstrb),
   .m_wvalid  (m_wvalid),
   .m_wready  (m_wready),
   .m_bvalid  (m_bvalid),
   .m_bready  (m_bready),
   .m_araddr  (m_araddr),
   .m_arprot  (m_arprot),
   .m_arvalid (m_arvalid),
   .m_arready (m_arready),
   .m_rready  (m_rready)
);

// File: tb/rmw_copy_engine_tb_top.sv
`timescale 1ns/1ps
module rmw_copy_engine_tb_top;

   localparam logic [31:0] SRC = 32'h4000_0000;
   localparam logic [31:0] DST = 32'h4000_07CC;
   localparam logic [31:0] ADD = 32'hABC0_0000;
   localparam logic [31:0] SENT = 32'hDEAD_BEEF;
   localparam logic [31:0] JUNK = 32'h5A5A_5A5A;
   localparam int N = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, error;
   logic [31:0] awaddr, wdata, araddr;
   logic [2:0]  awprot, arprot;
   logic [3:0]  wstrb;
   logic awvalid, wvalid, bready, arvalid, rready;
   logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0, arready = 1'b0, rvalid = 1'b0;
   logic [1:0]  bresp = 2'b00, rresp = 2'b00;
   logic [31:0] rdata = JUNK;

   always #2.5 clk = ~clk;

   rmw_copy_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(done), .error(error),
      .m_awaddr(awaddr), .m_awprot(awprot), .m_awvalid(awvalid), .m_awready(awready),
      .m_wdata(wdata), .m_wstrb(wstrb), .m_wvalid(wvalid), .m_wready(wready),
      .m_bresp(bresp), .m_bvalid(bvalid), .m_bready(bready),
      .m_araddr(araddr), .m_arprot(arprot), .m_arvalid(arvalid), .m_arready(arready),
      .m_rdata(rdata), .m_rresp(rresp), .m_rvalid(rvalid), .m_rready(rready)
   );

   // ---------------- slave model ----------------
   logic [31:0] src_mem [0:15];
   logic [31:0] dst_mem [0:15];
   int dly_aw = 0, dly_w = 0, dly_b = 0, dly_ar = 0, dly_r = 0;
   logic [31:0] err_raddr = 32'hFFFF_FFFF;
   logic [31:0] err_waddr = 32'hFFFF_FFFF;
   int c_aw, c_w, c_b, c_ar, c_r;
   logic aw_have, w_have, ar_have;
   logic [31:0] aw_a, w_d, ar_a;

   function automatic int widx(input logic [31:0] a, input logic [31:0] base);
      logic [31:0] d;
      d = (a - base) >> 2;
      return int'(d[3:0]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         awready <= 1'b0; wready <= 1'b0; bvalid <= 1'b0; arready <= 1'b0; rvalid <= 1'b0;
         bresp <= 2'b00; rresp <= 2'b00; rdata <= JUNK;
         aw_have <= 1'b0; w_have <= 1'b0; ar_have <= 1'b0;
         c_aw <= 0; c_w <= 0; c_b <= 0; c_ar <= 0; c_r <= 0;
         for (int k = 0; k < 16; k++) dst_mem[k] <= SENT;
      end else begin
         if (awready) begin
            awready <= 1'b0; aw_have <= 1'b1; aw_a <= awaddr; c_aw <= 0;
         end else if (awvalid && !aw_have) begin
            if (c_aw >= dly_aw) awready <= 1'b1; else c_aw <= c_aw + 1;
         end
         if (wready) begin
            wready <= 1'b0; w_have <= 1'b1; w_d <= wdata; c_w <= 0;
         end else if (wvalid && !w_have) begin
            if (c_w >= dly_w) wready <= 1'b1; else c_w <= c_w + 1;
         end
         if (bvalid) begin
            if (bready) begin bvalid <= 1'b0; bresp <= 2'b00; end
         end else if (aw_have && w_have) begin
            if (c_b >= dly_b) begin
               bvalid <= 1'b1;
               if (aw_a == err_waddr) bresp <= 2'b10;
               else dst_mem[widx(aw_a, DST)] <= w_d;
               aw_have <= 1'b0; w_have <= 1'b0; c_b <= 0;
            end else c_b <= c_b + 1;
         end
         if (arready) begin
            arready <= 1'b0; ar_have <= 1'b1; ar_a <= araddr; c_ar <= 0;
         end else if (arvalid && !ar_have) begin
            if (c_ar >= dly_ar) arready <= 1'b1; else c_ar <= c_ar + 1;
         end
         if (rvalid) begin
            if (rready) begin rvalid <= 1'b0; rdata <= JUNK; rresp <= 2'b00; end
         end else if (ar_have) begin
            if (c_r >= dly_r) begin
               rvalid <= 1'b1;
               rdata  <= src_mem[widx(ar_a, SRC)];
               rresp  <= (ar_a == err_raddr) ? 2'b10 : 2'b00;
               ar_have <= 1'b0; c_r <= 0;
            end else c_r <= c_r + 1;
         end
      end
   end

   // ---------------- bus monitor (sampled at negedge) ----------------
   int ar_n = 0, aw_n = 0, w_n = 0, ovl_n = 0, pair_n = 0, sig_n = 0, early_n = 0;
   logic [31:0] ar_log [0:255];
   logic [31:0] aw_log [0:255];
   logic rd_open = 1'b0, wr_open = 1'b0, awv_q = 1'b0, wv_q = 1'b0, bhs_q = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         rd_open <= 1'b0; wr_open <= 1'b0; awv_q <= 1'b0; wv_q <= 1'b0; bhs_q <= 1'b0;
      end else begin
         if (arvalid && wr_open) ovl_n <= ovl_n + 1;
         if ((awvalid || wvalid) && rd_open) ovl_n <= ovl_n + 1;
         if (bhs_q && arvalid) early_n <= early_n + 1;
         if ((awvalid && !awv_q) != (wvalid && !wv_q)) pair_n <= pair_n + 1;
         if (wstrb != 4'hF || awprot != 3'd0 || arprot != 3'd0) sig_n <= sig_n + 1;
         if (arvalid) rd_open <= 1'b1;
         if (rvalid && rready) rd_open <= 1'b0;
         if (awvalid) wr_open <= 1'b1;
         if (bvalid && bready) wr_open <= 1'b0;
         if (arvalid && arready) begin ar_log[ar_n[7:0]] <= araddr; ar_n <= ar_n + 1; end
         if (awvalid && awready) begin aw_log[aw_n[7:0]] <= awaddr; aw_n <= aw_n + 1; end
         if (wvalid && wready) w_n <= w_n + 1;
         awv_q <= awvalid; wv_q <= wvalid; bhs_q <= bvalid && bready;
      end
   end

   // ---------------- check bookkeeping ----------------
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_delays(input int aw, input int w, input int b, input int ar, input int r);
      dly_aw = aw; dly_w = w; dly_b = b; dly_ar = ar; dly_r = r;
   endtask

   task automatic load_set_a();
      logic [31:0] v [0:9];
      v = '{32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'hA, 32'hB, 32'hC, 32'hD, 32'hE};
      for (int i = 0; i < 16; i++) src_mem[i] = (i < N) ? v[i] : 32'h0;
   endtask

   task automatic load_set_b();
      for (int i = 0; i < 16; i++) src_mem[i] = 32'h1111_1111 * i;
      src_mem[0] = 32'hFFFF_FFFF;
      src_mem[1] = 32'h5440_0000;
      src_mem[2] = 32'h0000_0000;
      src_mem[3] = 32'h8000_0000;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int k;
      k = 0;
      while (!done && k < 5000) begin @(negedge clk); k++; end
      chk(tag, {31'd0, done}, 32'd1);
   endtask

   task automatic check_dst(input string tag, input int upto);
      for (int i = 0; i < upto; i++)
         chk(tag, dst_mem[i], src_mem[i] + ADD);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 reset valids/readies", {27'd0, awvalid, wvalid, bready, arvalid, rready}, 32'd0);
      chk("R11 reset status", {29'd0, busy, done, error}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 after reset valids", {27'd0, awvalid, wvalid, bready, arvalid, rready}, 32'd0);
      chk("R11 strobe/prot", {21'd0, wstrb, awprot, arprot}, {21'd0, 4'hF, 3'd0, 3'd0});
   endtask

   task automatic t_basic();
      int ar0, aw0, w0;
      do_reset(); set_delays(0, 0, 0, 0, 0); load_set_a();
      ar0 = ar_n; aw0 = aw_n; w0 = w_n;
      pulse_start();
      chk("R7 busy after start", {31'd0, busy}, 32'd1);
      wait_done("R8 done basic");
      chk("R8 error clear basic", {31'd0, error}, 32'd0);
      check_dst("R1 basic data", N);
      chk("R2 no extra write", dst_mem[N], SENT);
      chk("R2 read count", ar_n - ar0, N);
      chk("R2 write count", aw_n - aw0, N);
      chk("R1 one data beat per write", w_n - w0, N);
      for (int i = 0; i < N; i++) begin
         chk("R2 read address", ar_log[(ar0 + i) & 255], SRC + 32'(4 * i));
         chk("R2 write address", aw_log[(aw0 + i) & 255], DST + 32'(4 * i));
      end
      repeat (20) @(negedge clk);
      chk("R8 done sticky", {31'd0, done}, 32'd1);
      chk("R8 busy low", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_stall(input int aw, input int w, input int b, input int ar, input int r,
                          input string tag);
      do_reset(); set_delays(aw, w, b, ar, r); load_set_b();
      pulse_start();
      wait_done(tag);
      check_dst(tag, N);
      chk(tag, {31'd0, error}, 32'd0);
   endtask

   task automatic t_start_rules();
      int ar0;
      do_reset(); set_delays(1, 1, 1, 1, 1); load_set_a();
      ar0 = ar_n;
      @(negedge clk); start = 1'b1;
      @(negedge clk);
      wait_done("R7 held start run done");
      repeat (40) @(negedge clk);
      chk("R7 held start no rerun", ar_n - ar0, N);
      chk("R7 held start idle", {31'd0, busy}, 32'd0);
      start = 1'b0;
      ar0 = ar_n;
      pulse_start();
      chk("R8 done cleared by start", {31'd0, done}, 32'd0);
      repeat (15) @(negedge clk);
      pulse_start();
      wait_done("R7 mid-run pulse done");
      repeat (30) @(negedge clk);
      chk("R7 mid-run pulse ignored", ar_n - ar0, N);
      chk("R7 idle after run", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_rd_err();
      int ar0, aw0;
      do_reset(); set_delays(0, 1, 0, 0, 2); load_set_a();
      err_raddr = SRC + 32'd12;
      ar0 = ar_n; aw0 = aw_n;
      pulse_start();
      wait_done("R9 done on read error");
      repeat (30) @(negedge clk);
      chk("R9 error flag", {31'd0, error}, 32'd1);
      chk("R9 reads stop", ar_n - ar0, 4);
      chk("R9 writes stop", aw_n - aw0, 3);
      check_dst("R9 earlier words", 3);
      chk("R9 failed word untouched", dst_mem[3], SENT);
      err_raddr = 32'hFFFF_FFFF;
   endtask

   task automatic t_wr_err();
      int ar0, aw0;
      do_reset(); set_delays(2, 0, 1, 0, 0); load_set_b();
      err_waddr = DST + 32'd20;
      ar0 = ar_n; aw0 = aw_n;
      pulse_start();
      wait_done("R10 done on write error");
      repeat (30) @(negedge clk);
      chk("R10 error flag", {31'd0, error}, 32'd1);
      chk("R10 reads stop", ar_n - ar0, 6);
      chk("R10 writes stop", aw_n - aw0, 6);
      check_dst("R10 earlier words", 5);
      chk("R10 later word untouched", dst_mem[6], SENT);
      err_waddr = 32'hFFFF_FFFF;
      pulse_start();
      chk("R8 error cleared on start", {31'd0, error}, 32'd0);
      wait_done("R8 rerun after error");
      chk("R8 rerun error low", {31'd0, error}, 32'd0);
      check_dst("R8 rerun data", N);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_stall(3, 0, 2, 1, 4, "R6 stall aw-late data");
      t_stall(0, 3, 0, 2, 1, "R4 stall w-late data");
      t_stall(5, 5, 3, 4, 6, "R6 long stall data");
      t_start_rules();
      t_rd_err();
      t_wr_err();
      chk("R3 no overlapping transactions", ovl_n, 0);
      chk("R4 aw and w rise together", pair_n, 0);
      chk("R5 no read in B handshake cycle", early_n, 0);
      chk("R11 fixed strobe and prot", sig_n, 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule